// File: doc/BRIEF.md
# Banked Flash Operation Arbiter

This block sits in front of a 16-bank NOR flash array and decides, request by request, whether an operation may go ahead. A requester presents a read, program, erase, suspend, resume or status-clear operation together with a 23-bit word address. One cycle later the arbiter answers. The answer says whether the request was granted. For a read, it also says whether the access would reach array data or would fall on a busy location and get status back instead.

Only one program or erase job can be counting at any time. Its duration is a parameterised number of clock cycles, and the count holds still while the job is suspended. Suspends can nest. While an erase is suspended, a program may start outside the erased block, and that program may itself be suspended. Each level limits which locations may be read or programmed. A status word is always visible. It shows whether a job is counting, which suspends are in effect, a sticky completion flag and a sticky resume-error flag.

Top module: `flash_bank_arbiter`

## Requirements
- R1: The bank of a request is address bits [22:19], and it is reported on `rsp_bank` with every response. After reset `rsp_valid` is 0 and `status_o` is 0.
- R2: Each request sampled at a clock edge gets exactly one response in the following cycle (`rsp_valid`=1). Cycles with no request give `rsp_valid`=0 with all response flags 0. Operation codes are: 0 read, 1 program, 2 erase, 3 suspend, 4 resume, 5 clear. Codes 6 and 7 are answered without grant and have no effect.
- R3: Program is granted only when idle or while an erase is suspended. Erase is granted only when idle. At most one job counts at a time.
- R4: Reads are always granted. A read to a bank other than the one whose job is counting returns array data (`rsp_array`=1).
- R5: A read aimed at the bank of the counting job returns status (`rsp_array`=0, `rsp_conflict`=1).
- R6: While an erase is suspended, a read or a program may target any block except the erased one. A read there conflicts and a program there is rejected. Blocks are 64 Kword regions (address bits [22:16]), except the region with bits [22:16]=7Fh, which holds four 16 Kword blocks selected by bits [15:14].
- R7: While a program is suspended, only a read of the exact word being programmed conflicts.
- R8: Suspend is granted when a program is counting, when an erase is counting, or when a program is counting inside an erase suspend. Resume is granted from the matching suspended state and returns to it. In other states suspend is rejected.
- R9: A resume with no suspended job (idle, program counting, erase counting) is rejected, sets the sticky error bit `status_o[4]` and leaves the state unchanged. A resume while a program counts inside an erase suspend is rejected without error.
- R10: `status_o` bits are: [0] a job counting, [1] erase suspended, [2] program suspended, [3] done (sticky), [4] resume error (sticky), [7:5] zero. A program keeps bit 0 high for exactly PROG_CYCLES unsuspended cycles after its grant, and an erase for ERASE_CYCLES. Bit 3 is set at completion. A program finishing inside an erase suspend returns to the erase-suspended state.
- R11: A suspend arriving in the last counting cycle of the job it targets is rejected, and the job completes.
- R12: Clear is always granted and clears the done and error bits. A completion in the same cycle still sets done.
- R13: Consecutive reads that step across a bank boundary are each granted with array data when no job blocks them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 23 | Word address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_grant | output | 1 | Request accepted |
| rsp_conflict | output | 1 | Read fell on a busy or suspended location |
| rsp_array | output | 1 | Read returns array data |
| rsp_bank | output | 4 | Bank of the answered request |
| status_o | output | 8 | Status word |

## Verification
The hardest state to reach from the ports is the double suspend: a program suspended while it runs inside an erase suspend. The cases that matter most are reads and programs that hit the erased block, the programmed word or a neighbouring parameter block. A suspend that lands on the last counting cycle is also hard to reach. Directed sequences walk through the nested states with chosen parameter-block addresses. They also time a suspend onto the final count. Random traffic then draws addresses from a small pool of boundary and parameter-region words, so that conflicts, nested grants and bad resumes keep happening.

// File: rtl/fba_pkg.sv
package fba_pkg;
  localparam int ADDR_W = 23;
  localparam int BANK_W = 4;
  localparam int MAIN_W = 7;
  localparam int BLK_W  = MAIN_W + 2;
  localparam int STAT_W = 8;
  localparam logic [MAIN_W-1:0] PARAM_REGION = '1;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_CLEAR   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRUN     = 3'd1,
    ST_PSUS     = 3'd2,
    ST_ERUN     = 3'd3,
    ST_ESUS     = 3'd4,
    ST_ES_PRUN  = 3'd5,
    ST_ES_PSUS  = 3'd6
  } arb_state_e;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BANK_W];
  endfunction

  // main region: one block per 64 Kword; top region: four 16 Kword blocks
  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    logic [MAIN_W-1:0] reg_id;
    reg_id = a[ADDR_W-1 -: MAIN_W];
    if (reg_id == PARAM_REGION) return {reg_id, a[15:14]};
    return {reg_id, 2'b00};
  endfunction
endpackage

// File: rtl/fba_addr_guard.sv
module fba_addr_guard
  import fba_pkg::*;
(
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [ADDR_W-1:0] erase_addr,
  output logic              hit_prog_bank,
  output logic              hit_prog_word,
  output logic              hit_erase_bank,
  output logic              hit_erase_block
);
  always_comb begin
    hit_prog_bank   = bank_of(req_addr) == bank_of(prog_addr);
    hit_prog_word   = req_addr == prog_addr;
    hit_erase_bank  = bank_of(req_addr) == bank_of(erase_addr);
    hit_erase_block = block_of(req_addr) == block_of(erase_addr);
  end
endmodule

// File: rtl/fba_op_timer.sv
module fba_op_timer #(
  parameter int LOAD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int CW = $clog2(LOAD + 1);
  localparam logic [CW-1:0] START = CW'(LOAD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= START;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt)); // R10
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == START)); // R10
endmodule

// File: rtl/fba_arb_ctrl.sv
module fba_arb_ctrl
  import fba_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hit_prog_bank,
  input  logic              hit_prog_word,
  input  logic              hit_erase_bank,
  input  logic              hit_erase_block,
  input  logic              prog_zero,
  input  logic              erase_zero,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              prog_load,
  output logic              erase_load,
  output logic              prog_run,
  output logic              erase_run,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_conflict,
  output logic              rsp_array,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [STAT_W-1:0] status_o
);
  arb_state_e state, nstate;
  logic done_q, err_q;
  logic grant_n, conflict_n, clear_n, set_err_n;
  logic prog_fin, erase_fin;
  logic read_block;
  logic erase_susp, prog_susp;

  assign prog_run   = (state == ST_PRUN) || (state == ST_ES_PRUN);
  assign erase_run  = (state == ST_ERUN);
  assign prog_fin   = prog_run && prog_zero;
  assign erase_fin  = erase_run && erase_zero;
  assign erase_susp = (state == ST_ESUS) || (state == ST_ES_PRUN) || (state == ST_ES_PSUS);
  assign prog_susp  = (state == ST_PSUS) || (state == ST_ES_PSUS);

  // which read targets are off-limits in each state
  always_comb begin
    unique case (state)
      ST_PRUN:    read_block = hit_prog_bank;
      ST_PSUS:    read_block = hit_prog_word;
      ST_ERUN:    read_block = hit_erase_bank;
      ST_ESUS:    read_block = hit_erase_block;
      ST_ES_PRUN: read_block = hit_erase_block || hit_prog_bank;
      ST_ES_PSUS: read_block = hit_erase_block || hit_prog_word;
      default:    read_block = 1'b0;
    endcase
  end

  always_comb begin
    nstate     = state;
    grant_n    = 1'b0;
    conflict_n = 1'b0;
    clear_n    = 1'b0;
    set_err_n  = 1'b0;
    prog_load  = 1'b0;
    erase_load = 1'b0;
    if (req_valid) begin
      unique case (req_op)
        OP_READ: begin
          grant_n    = 1'b1;
          conflict_n = read_block;
        end
        OP_PROG: begin
          if (state == ST_IDLE) begin
            grant_n = 1'b1; prog_load = 1'b1; nstate = ST_PRUN;
          end else if (state == ST_ESUS && !hit_erase_block) begin
            grant_n = 1'b1; prog_load = 1'b1; nstate = ST_ES_PRUN;
          end
        end
        OP_ERASE: begin
          if (state == ST_IDLE) begin
            grant_n = 1'b1; erase_load = 1'b1; nstate = ST_ERUN;
          end
        end
        OP_SUSPEND: begin
          if (state == ST_PRUN && !prog_fin) begin
            grant_n = 1'b1; nstate = ST_PSUS;
          end else if (state == ST_ERUN && !erase_fin) begin
            grant_n = 1'b1; nstate = ST_ESUS;
          end else if (state == ST_ES_PRUN && !prog_fin) begin
            grant_n = 1'b1; nstate = ST_ES_PSUS;
          end
        end
        OP_RESUME: begin
          unique case (state)
            ST_PSUS:    begin grant_n = 1'b1; nstate = ST_PRUN;    end
            ST_ESUS:    begin grant_n = 1'b1; nstate = ST_ERUN;    end
            ST_ES_PSUS: begin grant_n = 1'b1; nstate = ST_ES_PRUN; end
            ST_ES_PRUN: ;
            default:    set_err_n = 1'b1;
          endcase
        end
        OP_CLEAR: begin
          grant_n = 1'b1;
          clear_n = 1'b1;
        end
        default: ;
      endcase
    end
    if (prog_fin)  nstate = (state == ST_ES_PRUN) ? ST_ESUS : ST_IDLE;
    if (erase_fin) nstate = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
      prog_addr    <= '0;
      erase_addr   <= '0;
      rsp_valid    <= 1'b0;
      rsp_grant    <= 1'b0;
      rsp_conflict <= 1'b0;
      rsp_array    <= 1'b0;
      rsp_bank     <= '0;
    end else begin
      state <= nstate;
      if (prog_load)  prog_addr  <= req_addr;
      if (erase_load) erase_addr <= req_addr;
      if (prog_fin || erase_fin) done_q <= 1'b1;
      else if (clear_n)          done_q <= 1'b0;
      if (set_err_n)    err_q <= 1'b1;
      else if (clear_n) err_q <= 1'b0;
      rsp_valid    <= req_valid;
      rsp_grant    <= grant_n;
      rsp_conflict <= conflict_n;
      rsp_array    <= req_valid && (req_op == OP_READ) && !read_block;
      rsp_bank     <= req_valid ? bank_of(req_addr) : '0;
    end
  end

  assign status_o = {3'b000, err_q, done_q, prog_susp, erase_susp, prog_run || erase_run};

  AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_run && erase_run)); // R3
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_CONFLICT_NO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_conflict) |-> !rsp_array); // R5
  AST_BAD_RESUME_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RESUME &&
     (state == ST_IDLE || state == ST_PRUN || state == ST_ERUN))
    |=> (!rsp_grant && status_o[4])); // R9
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fin || erase_fin) |=> status_o[3]); // R10
  AST_LATE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SUSPEND && (prog_fin || erase_fin)) |=> !rsp_grant); // R11
  AST_NESTED_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ES_PRUN && prog_fin) |=> (state == ST_ESUS)); // R10
endmodule

// File: rtl/flash_bank_arbiter.sv
module flash_bank_arbiter
  import fba_pkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_conflict,
  output logic              rsp_array,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [STAT_W-1:0] status_o
);
  logic [ADDR_W-1:0] prog_addr, erase_addr;
  logic hit_prog_bank, hit_prog_word, hit_erase_bank, hit_erase_block;
  logic prog_load, erase_load, prog_run, erase_run, prog_zero, erase_zero;

  fba_addr_guard u_guard (
    .req_addr        (req_addr),
    .prog_addr       (prog_addr),
    .erase_addr      (erase_addr),
    .hit_prog_bank   (hit_prog_bank),
    .hit_prog_word   (hit_prog_word),
    .hit_erase_bank  (hit_erase_bank),
    .hit_erase_block (hit_erase_block)
  );

  fba_op_timer #(.LOAD(PROG_CYCLES)) u_prog_timer (
    .clk (clk), .rst_n (rst_n), .load (prog_load), .run (prog_run), .zero (prog_zero)
  );

  fba_op_timer #(.LOAD(ERASE_CYCLES)) u_erase_timer (
    .clk (clk), .rst_n (rst_n), .load (erase_load), .run (erase_run), .zero (erase_zero)
  );

  fba_arb_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_op          (req_op),
    .req_addr        (req_addr),
    .hit_prog_bank   (hit_prog_bank),
    .hit_prog_word   (hit_prog_word),
    .hit_erase_bank  (hit_erase_bank),
    .hit_erase_block (hit_erase_block),
    .prog_zero       (prog_zero),
    .erase_zero      (erase_zero),
    .prog_addr       (prog_addr),
    .erase_addr      (erase_addr),
    .prog_load       (prog_load),
    .erase_load      (erase_load),
    .prog_run        (prog_run),
    .erase_run       (erase_run),
    .rsp_valid       (rsp_valid),
    .rsp_grant       (rsp_grant),
    .rsp_conflict    (rsp_conflict),
    .rsp_array       (rsp_array),
    .rsp_bank        (rsp_bank),
    .status_o        (status_o)
  );
endmodule

// File: tb/tb_flash_bank_arbiter.sv
`timescale 1ns/1ps
module tb_flash_bank_arbiter;
  localparam int PC = 6;
  localparam int EC = 14;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_op = 0;
  logic [22:0] req_addr = 0;
  logic rsp_valid, rsp_grant, rsp_conflict, rsp_array;
  logic [3:0] rsp_bank;
  logic [7:0] status_o;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  flash_bank_arbiter #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_conflict(rsp_conflict),
    .rsp_array(rsp_array), .rsp_bank(rsp_bank), .status_o(status_o)
  );

  // reference model states: 0 idle,1 prog,2 prog-susp,3 erase,4 erase-susp,5 prog in esus,6 both susp
  int ms = 0, mp = 0, me = 0;
  logic [22:0] mpa = 0, mea = 0;
  bit mdone = 0, merr = 0;

  function automatic int bk(input logic [22:0] a);
    return int'(a >> 19);
  endfunction

  function automatic int blk(input logic [22:0] a);
    if (a >= 23'h7F0000) return 1000 + int'((a - 23'h7F0000) / 16384);
    return int'(a / 65536);
  endfunction

  function automatic logic [7:0] mstat();
    logic [7:0] s = 0;
    s[0] = (ms == 1 || ms == 3 || ms == 5);
    s[1] = (ms == 4 || ms == 5 || ms == 6);
    s[2] = (ms == 2 || ms == 6);
    s[3] = mdone;
    s[4] = merr;
    return s;
  endfunction

  function automatic bit mread_blocked(input logic [22:0] a);
    case (ms)
      1: return bk(a) == bk(mpa);
      2: return a == mpa;
      3: return bk(a) == bk(mea);
      4: return blk(a) == blk(mea);
      5: return blk(a) == blk(mea) || bk(a) == bk(mpa);
      6: return blk(a) == blk(mea) || a == mpa;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int op, input logic [22:0] a, input string tag);
    bit g = 0, cf = 0, ar = 0, pfin, efin, prun, erun;
    int nx;
    logic [3:0] eb;
    prun = (ms == 1 || ms == 5);
    erun = (ms == 3);
    pfin = prun && mp == 0;
    efin = erun && me == 0;
    nx = ms;
    eb = v ? a[22:19] : 4'd0;
    if (v) begin
      case (op)
        0: begin g = 1; cf = mread_blocked(a); ar = !cf; end
        1: if (ms == 0) begin g = 1; nx = 1; end
           else if (ms == 4 && blk(a) != blk(mea)) begin g = 1; nx = 5; end
        2: if (ms == 0) begin g = 1; nx = 3; end
        3: if (ms == 1 && !pfin) begin g = 1; nx = 2; end
           else if (ms == 3 && !efin) begin g = 1; nx = 4; end
           else if (ms == 5 && !pfin) begin g = 1; nx = 6; end
        4: if (ms == 2) begin g = 1; nx = 1; end
           else if (ms == 4) begin g = 1; nx = 3; end
           else if (ms == 6) begin g = 1; nx = 5; end
           else if (ms != 5) merr = 1;
        5: begin g = 1; merr = 0; if (!(pfin || efin)) mdone = 0; end
        default: ;
      endcase
    end
    if (prun && !pfin) mp--;
    if (erun && !efin) me--;
    if (v && g && op == 1) begin mp = PC - 1; mpa = a; end
    if (v && g && op == 2) begin me = EC - 1; mea = a; end
    if (pfin || efin) mdone = 1;
    if (pfin) nx = (ms == 5) ? 4 : 0;
    if (efin) nx = 0;
    ms = nx;
    req_valid = v; req_op = 3'(op); req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(tag, {24'd0, rsp_valid, rsp_grant, rsp_conflict, rsp_array, rsp_bank},
               {24'd0, v, g, cf, ar, eb});
    check(tag, {24'd0, status_o}, {24'd0, mstat()});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  logic [22:0] pool [8] = '{23'h000000, 23'h000001, 23'h00FFFF, 23'h010000,
                            23'h07FFFF, 23'h080000, 23'h7F3FFF, 23'h7F4000};

  initial begin : watchdog
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset rsp_valid", {31'd0, rsp_valid}, 0);
    check("R1 reset status", {24'd0, status_o}, 0);

    // R13 / R1: reads across bank boundary
    step(1, 0, 23'h07FFFF, "R13");
    step(1, 0, 23'h080000, "R13 R1");
    step(1, 6, 23'h100000, "R2 invalid op");

    // program then conflicts
    step(1, 1, 23'h000010, "R3");
    step(1, 0, 23'h000020, "R5");
    step(1, 0, 23'h080000, "R4");
    step(1, 2, 23'h300000, "R3");
    step(1, 4, 23'h000000, "R9");
    idle(PC, "R10");
    step(1, 5, 0, "R12");

    // erase in parameter block, nested suspend
    step(1, 2, 23'h7F4000, "R3");
    idle(3, "R10");
    step(1, 3, 0, "R8");
    step(1, 0, 23'h7F4005, "R6");
    step(1, 0, 23'h7F0000, "R6");
    step(1, 1, 23'h7F4001, "R6");
    step(1, 1, 23'h7F8000, "R8");
    step(1, 0, 23'h7FC000, "R5");
    step(1, 4, 0, "R9");
    step(1, 3, 0, "R8");
    step(1, 0, 23'h7F8000, "R7");
    step(1, 0, 23'h7F8001, "R7");
    idle(2, "R10");
    step(1, 4, 0, "R8");
    idle(PC, "R10");
    step(1, 4, 0, "R8");
    idle(EC, "R10");

    // R11: suspend on final count cycle
    step(1, 5, 0, "R12");
    step(1, 1, 23'h123456, "R11");
    idle(PC - 1, "R11");
    step(1, 3, 0, "R11");
    idle(2, "R11");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r, op;
      logic [22:0] a;
      r = $urandom_range(0, 99);
      if (r < 35) op = 0; else if (r < 50) op = 1; else if (r < 62) op = 2;
      else if (r < 77) op = 3; else if (r < 89) op = 4; else if (r < 95) op = 5;
      else op = 6 + (r & 1);
      a = ($urandom_range(0, 9) < 8) ? pool[$urandom_range(0, 7)] + 23'($urandom_range(0, 2))
                                     : 23'($urandom);
      step($urandom_range(0, 9) != 0, op, a, "R2 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule